// File: doc/BRIEF.md
# Pin Bank with Summary Interrupt

A bank of `N_PINS` general-purpose pins controlled through a plain single-cycle register port. Software can set each pin to drive or to sample. It can read the synchronized level of every pin, and it can arm each pin as an interrupt source. The register port has no handshake and no back-pressure. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`.

Each pin has its own trigger detector, which works either on a single edge or on a level, with a chosen polarity. A detected trigger passes two separate gates. One gate decides whether a sticky status bit is recorded. The other decides whether the pin requests an interrupt. A third condition, a per-pin target code, decides whether that request reaches the single summary line `irq_summary`. Software clears the status bit by writing a 1 to it.

Top module: `pin_bank`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all low and `irq_summary` is low.
- R2: Per-pin block at 0x1000 + 0x10*i. Bit 9 of the setup word (+0x0) drives `pad_oe[i]`. Bit 1 of the data word (+0x4) drives `pad_out[i]`. Both read back.
- R3: Bit 0 of the data word shows `pad_in[i]` after two clock edges, no sooner.
- R4: The trigger word is at +0x8, with bit 0 = request enable, bit 1 = polarity, bit 2 = edge mode and bit 3 = status enable. With edge mode and polarity 1, a rising input sets status bit 0 (+0xC) on the third edge after the input change. `irq_summary` rises in the same cycle.
- R5: With edge mode and polarity 0, only a falling input triggers.
- R6: With status enable clear and request enable set, an edge gives a one-cycle pulse on `irq_summary` and records no status.
- R7: With request enable clear and status enable set, an edge records status and `irq_summary` stays low.
- R8: In level mode, with the pin armed, `irq_summary` stays high while the synchronized input equals the polarity. It falls one cycle after the synchronized input changes.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A trigger in the same cycle as a clear leaves it set.
- R10: The target word is at 0x400 + 4*i, bits 2:0. Only code 4 lets the pin reach `irq_summary`. Code 7, or any other code, blocks it.
- R11: `irq_summary` is high while any pin has an armed, targeted request. It falls only when the last such request goes away.
- R12: Unimplemented bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pad_in | input | N_PINS | Raw pin inputs |
| pad_out | output | N_PINS | Driven pin values |
| pad_oe | output | N_PINS | Pin output enables |
| irq_summary | output | 1 | OR of all targeted pin requests |

## Verification
The hardest case to reach from the ports is a status clear that lands in the same clock edge where a new edge is recorded. The bench counts edges from the input change, two through the synchronizer and one into the status flop. It schedules the clearing write so that it is sampled exactly on the recording edge. A second hard case is the status-less pulse of R6. It lasts a single cycle, so the bench samples it in that cycle and again in the cycle after it.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int PIN_BASE   = 'h1000;
  localparam int PIN_STRIDE = 16;
  localparam int TGT_BASE   = 'h400;
  localparam int TGT_STRIDE = 4;

  localparam int OE_BIT  = 9;
  localparam int IN_BIT  = 0;
  localparam int OUT_BIT = 1;
  localparam int TGT_W   = 3;

  localparam logic [TGT_W-1:0] TGT_CPU  = 3'd4;
  localparam logic [TGT_W-1:0] TGT_NONE = 3'd7;

  typedef enum logic [1:0] {
    RG_SETUP = 2'd0,
    RG_DATA  = 2'd1,
    RG_TRIG  = 2'd2,
    RG_STAT  = 2'd3
  } pin_reg_e;

  // trigger word, bit 3 down to bit 0
  typedef struct packed {
    logic sten;
    logic edge_mode;
    logic pol;
    logic ien;
  } trig_cfg_t;
endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pin_bank_slice.sv
module pin_bank_slice
  import pin_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             wr_setup,
  input  logic             wr_data,
  input  logic             wr_trig,
  input  logic             wr_stat,
  input  logic             wr_tgt,
  input  logic             wd_oe,
  input  logic             wd_out,
  input  trig_cfg_t        wd_trig,
  input  logic             wd_clr,
  input  logic [TGT_W-1:0] wd_tgt,
  output logic             oe_q,
  output logic             out_q,
  output trig_cfg_t        trig_q,
  output logic             stat_q,
  output logic [TGT_W-1:0] tgt_q,
  output logic             req
);
  logic prev_lvl;
  logic rise, fall, edge_hit, lvl_hit, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= 1'b0;
      out_q    <= 1'b0;
      trig_q   <= '0;
      tgt_q    <= '0;
      prev_lvl <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      if (wr_setup) oe_q   <= wd_oe;
      if (wr_data)  out_q  <= wd_out;
      if (wr_trig)  trig_q <= wd_trig;
      if (wr_tgt)   tgt_q  <= wd_tgt;
    end
  end

  assign rise     = lvl & ~prev_lvl;
  assign fall     = ~lvl & prev_lvl;
  assign edge_hit = trig_q.pol ? rise : fall;
  assign lvl_hit  = (lvl == trig_q.pol);
  assign hit      = trig_q.edge_mode ? edge_hit : lvl_hit;

  // recording a trigger takes priority over a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stat_q <= 1'b0;
    else if (trig_q.sten && hit)  stat_q <= 1'b1;
    else if (wr_stat && wd_clr)   stat_q <= 1'b0;
  end

  always_comb begin
    req = 1'b0;
    if (trig_q.ien && tgt_q == TGT_CPU)
      req = trig_q.edge_mode ? (hit | stat_q) : hit;
  end

  // R6: nothing is recorded while the status gate is closed
  a_r6_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_q.sten && !stat_q) |=> !stat_q);

  // R9: a trigger wins over a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q.sten && hit) |=> stat_q);
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              irq_summary
);
  localparam logic [ADDR_W-1:0] PIN_LO = ADDR_W'(PIN_BASE);
  localparam logic [ADDR_W-1:0] PIN_HI = ADDR_W'(PIN_BASE + N_PINS * PIN_STRIDE);
  localparam logic [ADDR_W-1:0] TGT_LO = ADDR_W'(TGT_BASE);
  localparam logic [ADDR_W-1:0] TGT_HI = ADDR_W'(TGT_BASE + N_PINS * TGT_STRIDE);
  localparam int PIN_SH = $clog2(PIN_STRIDE);
  localparam int TGT_SH = $clog2(TGT_STRIDE);

  logic [N_PINS-1:0] lvl;
  logic [N_PINS-1:0] stat_v, req_v, armed_v;
  trig_cfg_t [N_PINS-1:0] trig_v;
  logic [N_PINS-1:0][TGT_W-1:0] tgt_v;

  logic              pin_win, tgt_win;
  logic [ADDR_W-1:0] pin_off, tgt_off, pin_idx, tgt_idx;
  pin_reg_e          sel;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DATA_W-1:OE_BIT+1], bus_wdata[OE_BIT-1:4], bus_addr[1:0]};

  pin_bank_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
  );

  assign pin_win = (bus_addr >= PIN_LO) && (bus_addr < PIN_HI);
  assign tgt_win = (bus_addr >= TGT_LO) && (bus_addr < TGT_HI);
  assign pin_off = bus_addr - PIN_LO;
  assign tgt_off = bus_addr - TGT_LO;
  assign pin_idx = pin_off >> PIN_SH;
  assign tgt_idx = tgt_off >> TGT_SH;
  assign sel     = pin_reg_e'(pin_off[3:2]);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic hit_pin, hit_tgt;
    assign hit_pin = bus_we && pin_win && (pin_idx == ADDR_W'(i));
    assign hit_tgt = bus_we && tgt_win && (tgt_idx == ADDR_W'(i));

    pin_bank_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl[i]),
      .wr_setup (hit_pin && sel == RG_SETUP),
      .wr_data  (hit_pin && sel == RG_DATA),
      .wr_trig  (hit_pin && sel == RG_TRIG),
      .wr_stat  (hit_pin && sel == RG_STAT),
      .wr_tgt   (hit_tgt),
      .wd_oe    (bus_wdata[OE_BIT]),
      .wd_out   (bus_wdata[OUT_BIT]),
      .wd_trig  (trig_cfg_t'(bus_wdata[3:0])),
      .wd_clr   (bus_wdata[0]),
      .wd_tgt   (bus_wdata[TGT_W-1:0]),
      .oe_q     (pad_oe[i]),
      .out_q    (pad_out[i]),
      .trig_q   (trig_v[i]),
      .stat_q   (stat_v[i]),
      .tgt_q    (tgt_v[i]),
      .req      (req_v[i])
    );

    assign armed_v[i] = trig_v[i].ien && (tgt_v[i] == TGT_CPU);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (pin_win && pin_idx == ADDR_W'(i)) begin
        case (sel)
          RG_SETUP: bus_rdata[OE_BIT] = pad_oe[i];
          RG_DATA: begin
            bus_rdata[IN_BIT]  = lvl[i];
            bus_rdata[OUT_BIT] = pad_out[i];
          end
          RG_TRIG: bus_rdata[3:0] = trig_v[i];
          RG_STAT: bus_rdata[0]   = stat_v[i];
          default: bus_rdata = '0;
        endcase
      end
      if (tgt_win && tgt_idx == ADDR_W'(i))
        bus_rdata[TGT_W-1:0] = tgt_v[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_summary <= 1'b0;
    else        irq_summary <= |req_v;
  end

  // R11: any pending request shows on the summary line next cycle
  a_r11_any_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_v) |=> irq_summary);

  // R10: with no pin both enabled and targeted, the line stays low
  a_r10_none_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_v == '0) |=> !irq_summary);
endmodule

// File: tb/tb_pin_bank.sv
module tb_pin_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic        irq_summary;

  int checks = 0;
  int errors = 0;

  typedef struct { string req; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank #(.N_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_summary(irq_summary)
  );

  function automatic logic [15:0] pa(int i, int r);
    return 16'(16'h1000 + i * 16 + r * 4);
  endfunction
  function automatic logic [15:0] ta(int i);
    return 16'(16'h400 + i * 4);
  endfunction

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  // driver side: push expectation
  task automatic expect_val(string req, logic [31:0] exp);
    exp_t e;
    e.req = req; e.exp = exp;
    sb_q.push_back(e);
  endtask

  // monitor side: pop and compare with an observed value
  task automatic observe(logic [31:0] act);
    exp_t e;
    e = sb_q.pop_front();
    checks++;
    if (act !== e.exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", e.req, act, e.exp);
    end
  endtask

  task automatic chk_rd(string req, logic [15:0] a, logic [31:0] exp);
    expect_val(req, exp);
    bus_addr = a;
    #1;
    observe(bus_rdata);
  endtask

  task automatic chk_irq(string req, logic exp);
    expect_val(req, 32'(exp));
    observe(32'(irq_summary));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 setup0", pa(0,0), 0);
    chk_rd("R1 data0", pa(0,1), 0);
    chk_rd("R1 trig0", pa(0,2), 0);
    chk_rd("R1 stat0", pa(0,3), 0);
    chk_rd("R1 tgt0", ta(0), 0);
    expect_val("R1 pads", 0); observe(32'({pad_oe, pad_out}));
    chk_irq("R1 summary", 0);

    // R2 output enable and drive, R12 stray bits
    wr(pa(1,0), 32'hFFFF_FFFF);
    chk_rd("R12 setup bits", pa(1,0), 32'h200);
    expect_val("R2 pad_oe", 32'h2); observe(32'(pad_oe));
    wr(pa(1,1), 32'h2);
    chk_rd("R2 data readback", pa(1,1), 32'h2);
    expect_val("R2 pad_out", 32'h2); observe(32'(pad_out));

    // R3 two-edge synchronizer
    pad_in[2] = 1'b1;
    tick();
    chk_rd("R3 after one edge", pa(2,1), 0);
    tick();
    chk_rd("R3 after two edges", pa(2,1), 1);

    // R4 rising edge, status and summary, R9 write-0 and write-1
    wr(ta(0), 4); wr(pa(0,2), 32'hF);
    pad_in[0] = 1'b1;
    tick(2);
    chk_rd("R4 status not yet", pa(0,3), 0);
    chk_irq("R4 summary not yet", 0);
    tick();
    chk_rd("R4 status set", pa(0,3), 1);
    chk_irq("R4 summary up", 1);
    wr(pa(0,3), 0);
    chk_rd("R9 write zero keeps", pa(0,3), 1);
    wr(pa(0,3), 1);
    chk_rd("R9 write one clears", pa(0,3), 0);
    tick();
    chk_irq("R9 summary down", 0);

    // R5 falling edge only
    wr(ta(3), 4); wr(pa(3,2), 32'hD);
    pad_in[3] = 1'b1; tick(3);
    chk_rd("R5 rise ignored", pa(3,3), 0);
    pad_in[3] = 1'b0; tick(3);
    chk_rd("R5 fall recorded", pa(3,3), 1);
    chk_irq("R5 summary up", 1);
    wr(pa(3,3), 1); tick();
    chk_irq("R5 summary down", 0);

    // R6 pulse without status
    wr(ta(4), 4); wr(pa(4,2), 32'h7);
    pad_in[4] = 1'b1; tick(3);
    chk_irq("R6 pulse high", 1);
    chk_rd("R6 no status", pa(4,3), 0);
    tick();
    chk_irq("R6 pulse over", 0);

    // R7 status without request
    wr(ta(5), 4); wr(pa(5,2), 32'hE);
    pad_in[5] = 1'b1; tick(3);
    chk_rd("R7 status set", pa(5,3), 1);
    chk_irq("R7 summary low", 0);
    tick();
    chk_irq("R7 summary still low", 0);
    wr(pa(5,3), 1);

    // R10 target code gating
    wr(ta(6), 32'hFF);
    chk_rd("R10 tgt readback", ta(6), 7);
    wr(pa(6,2), 32'hF);
    pad_in[6] = 1'b1; tick(3);
    chk_rd("R10 status with code 7", pa(6,3), 1);
    chk_irq("R10 blocked by code 7", 0);
    wr(ta(6), 4); tick();
    chk_irq("R10 passes with code 4", 1);
    wr(pa(6,3), 1); tick();
    chk_irq("R10 cleared", 0);

    // R8 level mode
    wr(ta(7), 4); wr(pa(7,2), 32'h3);
    pad_in[7] = 1'b1; tick(2);
    chk_irq("R8 level not yet", 0);
    tick();
    chk_irq("R8 level high", 1);
    tick(4);
    chk_irq("R8 level held", 1);
    pad_in[7] = 1'b0; tick(2);
    chk_irq("R8 one more cycle", 1);
    tick();
    chk_irq("R8 level released", 0);

    // R11 two pending pins
    pad_in[0] = 1'b0; tick(3);
    pad_in[0] = 1'b1; tick(3);
    pad_in[3] = 1'b1; tick(3);
    pad_in[3] = 1'b0; tick(3);
    chk_irq("R11 both pending", 1);
    wr(pa(0,3), 1); tick();
    chk_irq("R11 one left", 1);
    wr(pa(3,3), 1); tick();
    chk_irq("R11 none left", 0);

    // R9 clear in the recording cycle
    pad_in[0] = 1'b0; tick(3);
    chk_rd("R9 pre status", pa(0,3), 0);
    pad_in[0] = 1'b1; tick(2);
    wr(pa(0,3), 1);
    chk_rd("R9 set wins over clear", pa(0,3), 1);
    wr(pa(0,3), 1);
    chk_rd("R9 later clear", pa(0,3), 0);

    // R12 unmapped space
    chk_rd("R12 hole", 16'h0800, 0);
    chk_rd("R12 past last pin", pa(N,0), 0);
    chk_rd("R12 past last tgt", ta(N), 0);
    wr(pa(0,2), 32'hFFFF_FFFF);
    chk_rd("R12 trig bits", pa(0,2), 32'hF);

    finish_run();
  end
endmodule